// File: doc/BRIEF.md
# Input Word Unpacker with LSB Split

This block accepts 32-bit words from a host, buffers them in an input queue and splits each word into two 16-bit samples. The least significant bit of every sample is stripped. The remaining 15-bit value, zero-extended to 16 bits, is written to a sample queue that feeds a compressor. The stripped bits are gathered eight at a time into bytes, and each byte goes into a separate LSB queue. Both output queues are read through plain show-ahead read ports.

The host writes only while `host_ready` is high. That signal is tied to a fill threshold of one quarter on the input queue. A sequencer with three states does the unpacking: `SQ_IDLE`, `SQ_HI` and `SQ_LO`. `SQ_IDLE` moves to `SQ_HI` once a word is waiting. `SQ_HI` emits the upper half and moves to `SQ_LO`. `SQ_LO` emits the lower half, pops the word, and then returns to `SQ_HI` if another word is already queued, or falls back to `SQ_IDLE` if not. In `SQ_HI` and `SQ_LO` the sequencer waits in place if the sample queue is full. It also waits in place when the LSB queue is full and the current sample would complete a byte. Overflow and underflow events set sticky flags, and the enabled flags are ORed into an interrupt.

Top module: `lsb_split_unpacker`

## Requirements
- R1: `host_ready` is high exactly when the input queue holds at most IN_DEPTH/4 words.
- R2: Samples leave in word arrival order, with the upper half (bits 31:16) of each word first. Each sample is presented as {1'b0, half[15:1]}.
- R3: The LSB of sample 8j+b is placed in bit b of LSB byte j, so the first sample of a group goes into bit 0.
- R4: The sample queue is never written while it is full. The sequencer waits, no sample is lost, and words stay in the input queue.
- R5: A sample whose LSB would complete a byte is held back while the LSB queue is full. It is emitted once a byte has been read.
- R6: A write to a full input queue is dropped and sets error flag bit 0.
- R7: A read of an empty sample queue sets flag bit 1, and a read of an empty LSB queue sets flag bit 2. The read has no effect.
- R8: Error flags stay set until `err_clr` pulses a one in the same bit position.
- R9: `irq` is the OR over the flags that have the matching `irq_en` bit set.
- R10: After reset, all flags are clear, both output queues are empty and `host_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_wr | input | 1 | Host write strobe |
| in_data | input | 32 | Host word, two samples |
| host_ready | output | 1 | Input queue at or below one quarter |
| smp_rd | input | 1 | Pop sample queue |
| smp_valid | output | 1 | Sample queue not empty |
| smp_data | output | 16 | Head sample, 15 bits zero-extended |
| lsb_rd | input | 1 | Pop LSB queue |
| lsb_valid | output | 1 | LSB queue not empty |
| lsb_data | output | 8 | Head LSB byte |
| irq_en | input | 3 | Interrupt enable per flag |
| err_clr | input | 3 | Write-one-to-clear pulse per flag |
| err_flags | output | 3 | Sticky flags {lsb underflow, sample underflow, input overflow} |
| irq | output | 1 | Interrupt |

## Verification
The assertions allow the host to ignore `host_ready` and allow reads of empty queues. Those events are defined to raise flags, not to corrupt the queues. The assertions do expect `err_clr` to be a pulse under the host's control, so a flag with no clear pending must stay set. The stimulus provokes overflow and both underflows on purpose, once each. Apart from those cases it writes only on a free slot and reads only while data is valid, so every data check has a defined expected sample.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HI   = 2'd1,
        SQ_LO   = 2'd2
    } sq_state_t;

    localparam int ERR_W       = 3;
    localparam int ERR_IN_OVF  = 0;
    localparam int ERR_SMP_UDF = 1;
    localparam int ERR_LSB_UDF = 2;
endpackage

// File: rtl/lsu_fifo.sv
module lsu_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [W-1:0]                 wdata,
    input  logic                         rd,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_wr, do_rd;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
            count <= count + CW'(do_wr) - CW'(do_rd);
        end
    end
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
    import lsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] in_word,
    input  logic        in_empty,
    input  logic        in_multi,
    input  logic        smp_full,
    input  logic        lsb_full,
    output logic        in_pop,
    output logic        smp_wr,
    output logic [15:0] smp_wdata,
    output logic        lsb_wr,
    output logic [7:0]  lsb_wdata
);
    sq_state_t  state_q, state_d;
    logic [2:0] bit_cnt_q;
    logic [6:0] acc_q;
    logic [15:0] half;
    logic       byte_done, go;

    assign half      = (state_q == SQ_HI) ? in_word[31:16] : in_word[15:0];
    assign byte_done = (bit_cnt_q == 3'd7);
    assign go        = (state_q != SQ_IDLE) && !smp_full && !(byte_done && lsb_full);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (!in_empty) state_d = SQ_HI;
            SQ_HI:   if (go) state_d = SQ_LO;
            SQ_LO:   if (go) state_d = in_multi ? SQ_HI : SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            bit_cnt_q <= '0;
            acc_q     <= '0;
        end else begin
            state_q <= state_d;
            if (go) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                acc_q     <= {half[0], acc_q[6:1]};
            end
        end
    end

    always_comb begin
        smp_wr    = go;
        smp_wdata = {1'b0, half[15:1]};
        lsb_wr    = go && byte_done;
        lsb_wdata = {half[0], acc_q};
        in_pop    = go && (state_q == SQ_LO);
    end
endmodule

// File: rtl/lsb_split_unpacker.sv
module lsb_split_unpacker
    import lsu_pkg::*;
#(
    parameter int IN_DEPTH  = 256,
    parameter int SMP_DEPTH = 512,
    parameter int LSB_DEPTH = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_wr,
    input  logic [31:0]      in_data,
    output logic             host_ready,
    input  logic             smp_rd,
    output logic             smp_valid,
    output logic [15:0]      smp_data,
    input  logic             lsb_rd,
    output logic             lsb_valid,
    output logic [7:0]       lsb_data,
    input  logic [ERR_W-1:0] irq_en,
    input  logic [ERR_W-1:0] err_clr,
    output logic [ERR_W-1:0] err_flags,
    output logic             irq
);
    localparam int ICW    = $clog2(IN_DEPTH+1);
    localparam int SCW    = $clog2(SMP_DEPTH+1);
    localparam int LCW    = $clog2(LSB_DEPTH+1);
    localparam int READY_LIM = IN_DEPTH / 4;

    logic [31:0]  in_word;
    logic [ICW-1:0] in_cnt;
    logic [SCW-1:0] smp_cnt;
    logic [LCW-1:0] lsb_cnt;
    logic in_full, in_empty, in_pop;
    logic smp_full, smp_empty, smp_wr;
    logic lsb_full, lsb_empty, lsb_wr;
    logic [15:0] smp_wdata;
    logic [7:0]  lsb_wdata;
    logic [ERR_W-1:0] err_set;

    lsu_fifo #(.W(32), .DEPTH(IN_DEPTH)) u_in (
        .clk(clk), .rst_n(rst_n), .wr(in_wr), .wdata(in_data), .rd(in_pop),
        .rdata(in_word), .count(in_cnt), .full(in_full), .empty(in_empty));

    lsu_seq u_seq (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_empty(in_empty),
        .in_multi(in_cnt > ICW'(1)), .smp_full(smp_full), .lsb_full(lsb_full),
        .in_pop(in_pop), .smp_wr(smp_wr), .smp_wdata(smp_wdata),
        .lsb_wr(lsb_wr), .lsb_wdata(lsb_wdata));

    lsu_fifo #(.W(16), .DEPTH(SMP_DEPTH)) u_smp (
        .clk(clk), .rst_n(rst_n), .wr(smp_wr), .wdata(smp_wdata), .rd(smp_rd),
        .rdata(smp_data), .count(smp_cnt), .full(smp_full), .empty(smp_empty));

    lsu_fifo #(.W(8), .DEPTH(LSB_DEPTH)) u_lsb (
        .clk(clk), .rst_n(rst_n), .wr(lsb_wr), .wdata(lsb_wdata), .rd(lsb_rd),
        .rdata(lsb_data), .count(lsb_cnt), .full(lsb_full), .empty(lsb_empty));

    assign host_ready = (in_cnt <= ICW'(READY_LIM));
    assign smp_valid  = !smp_empty;
    assign lsb_valid  = !lsb_empty;

    always_comb begin
        err_set              = '0;
        err_set[ERR_IN_OVF]  = in_wr && in_full;
        err_set[ERR_SMP_UDF] = smp_rd && smp_empty;
        err_set[ERR_LSB_UDF] = lsb_rd && lsb_empty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_flags <= '0;
        else        err_flags <= (err_flags & ~err_clr) | err_set;
    end

    assign irq = |(err_flags & irq_en);
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ready,
    input logic       in_full,
    input logic       smp_full,
    input logic       smp_wr,
    input logic       lsb_full,
    input logic       lsb_wr,
    input logic [2:0] err_flags,
    input logic [2:0] err_clr,
    input logic       irq
);
    p_full_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_full |-> !host_ready);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_full |-> !smp_wr);

    p_no_lsb_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lsb_full |-> !lsb_wr);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flags & $past(err_flags & ~err_clr)) == $past(err_flags & ~err_clr)));

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (err_flags != 3'b000));
endmodule

bind lsb_split_unpacker lsu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .in_full(in_full),
    .smp_full(smp_full), .smp_wr(smp_wr), .lsb_full(lsb_full), .lsb_wr(lsb_wr),
    .err_flags(err_flags), .err_clr(err_clr), .irq(irq));

// File: tb/lsb_split_unpacker_test.sv
module lsb_split_unpacker_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_wr = 1'b0;
    logic [31:0] in_data = '0;
    logic host_ready, smp_valid, lsb_valid, irq;
    logic smp_rd = 1'b0, lsb_rd = 1'b0;
    logic [15:0] smp_data;
    logic [7:0] lsb_data;
    logic [2:0] irq_en = '0, err_clr = '0, err_flags;

    int checks = 0, errors = 0;
    int n_acc = 0, smp_seen = 0, lsb_seen = 0;
    logic [31:0] acc [0:31];

    always #4 clk = ~clk;

    lsb_split_unpacker #(.IN_DEPTH(8), .SMP_DEPTH(8), .LSB_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_data(in_data),
        .host_ready(host_ready), .smp_rd(smp_rd), .smp_valid(smp_valid),
        .smp_data(smp_data), .lsb_rd(lsb_rd), .lsb_valid(lsb_valid),
        .lsb_data(lsb_data), .irq_en(irq_en), .err_clr(err_clr),
        .err_flags(err_flags), .irq(irq));

    function automatic logic [31:0] gen(int k);
        return (32'(k) * 32'h9E37_79B1) ^ 32'h5A17_C3E6;
    endfunction

    function automatic logic [15:0] half_of(int i);
        logic [31:0] w = acc[i/2];
        return (i % 2 == 0) ? w[31:16] : w[15:0];
    endfunction

    function automatic logic [7:0] lsb_byte(int j);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[k] = half_of(8*j + k)[0];
        return b;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(int k, bit kept);
        @(negedge clk);
        in_wr = 1'b1; in_data = gen(k);
        @(negedge clk);
        in_wr = 1'b0;
        if (kept) begin acc[n_acc] = gen(k); n_acc++; end
    endtask

    task automatic drain(int limit, output int got);
        int idle = 0;
        got = 0;
        while (idle < 20 && got < limit) begin
            @(negedge clk);
            smp_rd = 1'b0;
            if (smp_valid) begin
                idle = 0;
                check(smp_data == {1'b0, half_of(smp_seen)[15:1]}, "R2", 32'(smp_data),
                      32'({1'b0, half_of(smp_seen)[15:1]}));
                smp_seen++; got++;
                smp_rd = 1'b1;
            end else idle++;
        end
        @(negedge clk);
        smp_rd = 1'b0;
    endtask

    task automatic pop_lsb();
        @(negedge clk);
        check(lsb_valid && lsb_data == lsb_byte(lsb_seen), "R3", 32'(lsb_data),
              32'(lsb_byte(lsb_seen)));
        lsb_seen++;
        lsb_rd = 1'b1;
        @(negedge clk);
        lsb_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int got;
        settle(3);
        rst_n = 1'b1;
        settle(2);
        // R10 reset state
        check(err_flags == 3'b000 && !irq, "R10", 32'(err_flags), 0);
        check(!smp_valid && !lsb_valid, "R10", 32'({smp_valid, lsb_valid}), 0);
        check(host_ready, "R10", 32'(host_ready), 1);

        // fill the sample queue: 4 words = 8 samples
        for (int k = 0; k < 4; k++) put(k, 1'b1);
        settle(20);
        check(host_ready, "R1", 32'(host_ready), 1);
        check(lsb_valid, "R3", 32'(lsb_valid), 1);
        // stalled sequencer: words accumulate, ready sweep over fill level (R1, R4)
        for (int k = 1; k <= 8; k++) begin
            put(3 + k, 1'b1);
            settle(4);
            check(host_ready == (k <= 2), "R1", 32'(host_ready), 32'(k <= 2));
        end
        // overflow write dropped (R6)
        put(12, 1'b0);
        settle(2);
        check(err_flags == 3'b001, "R6", 32'(err_flags), 3'b001);
        check(!irq, "R9", 32'(irq), 0);
        irq_en = 3'b111;
        settle(1);
        check(irq, "R9", 32'(irq), 1);
        settle(3);
        check(err_flags == 3'b001, "R8", 32'(err_flags), 3'b001);
        @(negedge clk); err_clr = 3'b001;
        @(negedge clk); err_clr = 3'b000;
        check(err_flags == 3'b000 && !irq, "R8", 32'(err_flags), 0);

        // drain all 24 samples in order (R2, R4 no loss)
        drain(100, got);
        check(got == 24, "R4", 32'(got), 24);

        // LSB queue holds 3 bytes; feed 8 more words without reading LSBs (R5)
        for (int k = 13; k <= 20; k++) begin
            put(k, 1'b1);
            drain(100, got);
        end
        check(smp_seen == 39, "R5", 32'(smp_seen), 39);
        check(!smp_valid, "R5", 32'(smp_valid), 0);
        pop_lsb();
        settle(4);
        check(smp_valid, "R5", 32'(smp_valid), 1);
        drain(100, got);
        check(smp_seen == 40, "R5", 32'(smp_seen), 40);
        for (int j = 0; j < 4; j++) pop_lsb();
        check(!lsb_valid, "R3", 32'(lsb_valid), 0);

        // underflow reads (R7) with partial masking (R9)
        irq_en = 3'b001;
        @(negedge clk); smp_rd = 1'b1;
        @(negedge clk); smp_rd = 1'b0;
        check(err_flags == 3'b010, "R7", 32'(err_flags), 3'b010);
        @(negedge clk); lsb_rd = 1'b1;
        @(negedge clk); lsb_rd = 1'b0;
        check(err_flags == 3'b110, "R7", 32'(err_flags), 3'b110);
        check(!irq, "R9", 32'(irq), 0);
        check(!smp_valid && !lsb_valid, "R7", 32'({smp_valid, lsb_valid}), 0);
        irq_en = 3'b100;
        settle(1);
        check(irq, "R9", 32'(irq), 1);
        @(negedge clk); err_clr = 3'b010;
        @(negedge clk); err_clr = 3'b000;
        check(err_flags == 3'b100, "R8", 32'(err_flags), 3'b100);
        // a fresh word after underflow still unpacks correctly
        put(21, 1'b1);
        drain(2, got);
        check(got == 2, "R2", 32'(got), 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule